// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block sits beside the access sequencer of an asynchronous DRAM controller. It owns two duties: bringing the memory up after power is applied, and keeping its contents alive. On reset it first waits out a programmable settling pause. It then asks the sequencer for a run of refresh slots. It reports the memory as usable only once the pause has elapsed and all of those start-up refreshes have finished.

From then on, an interval timer adds one owed refresh every `REF_INTERVAL` clock cycles. The default of 1560 cycles at 100 MHz spreads 4096 row refreshes evenly over 64 ms. Refreshes are of the CAS-before-RAS kind. The memory picks the row itself, so the block drives no address.

Whenever at least one refresh is owed and the block is idle, it raises `ref_req`. When the sequencer answers with `ref_gnt`, the block takes over the strobes and plays one complete refresh cycle: CAS falls first, RAS follows, both rise together, and a precharge gap closes the cycle. While it does this it holds `ref_active` high so the sequencer can switch its strobe outputs over. A refresh that cannot be granted straight away is not lost. It stays owed, up to a saturating limit, and is served at the next grant.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `ref_req` stays low and both strobes stay high for `PAUSE_CYC` cycles. `ref_req` is first sampled high after the `PAUSE_CYC`-th rising edge.
- R2: `init_done` stays low until the pause has elapsed and `INIT_REFS` refresh cycles have completed. It rises in the cycle in which the last of those precharge phases ends, and once high it stays high until reset.
- R3: A refresh cycle keeps `cas_n` low and `ras_n` high for `CAS_LEAD` cycles. It then holds both low for `RAS_LOW` cycles, after which both return high in the same cycle. `ras_n` is never low while `cas_n` is high.
- R4: `we_n` is high in every cycle, so no refresh cycle can be taken as a write.
- R5: After the strobes rise, the block keeps `ref_active` high with both strobes high for `RAS_PRE` cycles before a further refresh can begin.
- R6: A refresh begins only in the cycle after a rising edge at which `ref_req` and `ref_gnt` were both high. A high `ref_gnt` while `ref_req` is low has no effect on the strobes.
- R7: Once `init_done` is high, one refresh becomes owed every `REF_INTERVAL` cycles. The first is owed `REF_INTERVAL` cycles after `init_done` rises.
- R8: Owed refreshes accumulate while no grant arrives. Each completed refresh removes one, and `ref_req` stays high while the block is idle and any refresh is owed.
- R9: The owed count saturates at 2^`OWE_W`-1. Further interval expiries beyond that limit are dropped.
- R10: `ref_active` is high exactly from the cycle after a grant through the last precharge cycle. While it is low, both strobes are high, and `ref_req` is never high while `ref_active` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset; also marks power-up |
| ref_gnt | input | 1 | Sequencer grants the strobes to the block for one refresh |
| ref_req | output | 1 | A start-up or periodic refresh is waiting for a slot |
| ref_active | output | 1 | Block is driving the strobes this cycle |
| init_done | output | 1 | Pause and start-up refreshes complete; normal traffic may flow |
| ras_n | output | 1 | Row strobe, active low, valid while `ref_active` |
| cas_n | output | 1 | Column strobe, active low, valid while `ref_active` |
| we_n | output | 1 | Write enable, held high (inactive) |

## Verification
Some rules hold on every cycle, and embedded properties watch them continuously. These are: CAS must be low whenever RAS is low and in the cycle before RAS falls; strobes stay idle and no request is raised outside a refresh; a CAS fall must follow a sampled request-and-grant; and `init_done` never falls. The other behaviours are counts over time, and only the bench's scenarios can show them. These are the exact pause length, the exact phase lengths of the strobe waveform, `init_done` appearing precisely after the eighth start-up refresh, the spacing of periodic requests, the backlog being served back to back, and saturation of the owed count.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_REFS    = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int CAS_LEAD     = 1,
  parameter int RAS_LOW      = 5,
  parameter int RAS_PRE      = 3,
  parameter int OWE_W        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_active,
  output logic init_done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int TW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(REF_INTERVAL + 1);
  localparam int NW = $clog2(INIT_REFS + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_CSR, S_RASL, S_RP} st_t;

  st_t             state;
  logic [TW-1:0]   tcnt, plen;
  logic [IW-1:0]   ivl;
  logic [NW-1:0]   init_left;
  logic [OWE_W-1:0] owed;
  logic            tlast, fin, tick, take;

  always_comb begin
    case (state)
      S_PAUSE: plen = TW'(PAUSE_CYC);
      S_CSR:   plen = TW'(CAS_LEAD);
      S_RASL:  plen = TW'(RAS_LOW);
      default: plen = TW'(RAS_PRE);
    endcase
  end

  assign tlast      = tcnt == plen - TW'(1);
  assign fin        = state == S_RP && tlast;
  assign init_done  = state != S_PAUSE && init_left == '0;
  assign tick       = init_done && ivl == IW'(REF_INTERVAL - 1);
  assign ref_req    = state == S_IDLE && (init_left != '0 || owed != '0);
  assign take       = ref_req && ref_gnt;
  assign ref_active = state == S_CSR || state == S_RASL || state == S_RP;
  assign cas_n      = !(state == S_CSR || state == S_RASL);
  assign ras_n      = state != S_RASL;
  assign we_n       = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_PAUSE;
      tcnt  <= '0;
    end else if (state == S_IDLE) begin
      tcnt <= '0;
      if (take) state <= S_CSR;
    end else if (tlast) begin
      tcnt <= '0;
      case (state)
        S_PAUSE: state <= S_IDLE;
        S_CSR:   state <= S_RASL;
        S_RASL:  state <= S_RP;
        default: state <= S_IDLE;
      endcase
    end else begin
      tcnt <= tcnt + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) init_left <= NW'(INIT_REFS);
    else if (fin && init_left != '0) init_left <= init_left - NW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ivl <= '0;
    else if (init_done) ivl <= tick ? '0 : ivl + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else case ({tick, fin && init_left == '0})
      2'b10:   if (owed != '1) owed <= owed + OWE_W'(1);
      2'b01:   owed <= owed - OWE_W'(1);
      default: owed <= owed;
    endcase
  end

  assert_ras_under_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !$past(cas_n));
  assert_idle_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_active |-> (ras_n && cas_n));
  assert_req_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !ref_active);
  assert_start_on_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(ref_req && ref_gnt));
  assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
  localparam int PAUSE = 50;
  localparam int NINIT = 8;
  localparam int IVL   = 40;

  // per cycle after grant: {ref_active, ras_n, cas_n}
  localparam logic [2:0] SEQ [10] = '{3'b110, 3'b100, 3'b100, 3'b100, 3'b100,
                                      3'b100, 3'b111, 3'b111, 3'b111, 3'b011};

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic ref_req, ref_active, init_done, ras_n, cas_n, we_n;
  integer n_chk = 0, n_bad = 0;
  bit ok;
  integer served;

  always #5 clk = ~clk;

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_REFS(NINIT), .REF_INTERVAL(IVL),
    .CAS_LEAD(1), .RAS_LOW(5), .RAS_PRE(3), .OWE_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_active(ref_active), .init_done(init_done), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n));

  task automatic chk(input bit good, input string tag, input integer act, input integer exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_ref();
    ref_gnt = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 0) ref_gnt = 0;
      chk({ref_active, ras_n, cas_n} == SEQ[i], "R3 R5 R10 strobe step",
          {ref_active, ras_n, cas_n}, SEQ[i]);
      chk(we_n == 1'b1, "R4 we_n high", we_n, 1);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ref_req && !init_done && !ref_active && ras_n && cas_n, "R1 reset state",
        {ref_req, init_done, ref_active, ras_n, cas_n}, 5'b00011);
    rst_n   = 1;
    ref_gnt = 1;  // R6: grant without request during the pause
    ok = 1;
    for (int k = 1; k < PAUSE; k++) begin
      @(negedge clk);
      if (ref_req || !ras_n || !cas_n || ref_active) ok = 0;
    end
    chk(ok, "R1 R6 quiet during pause", ok, 1);
    ref_gnt = 0;
    @(negedge clk);
    chk(ref_req == 1, "R1 request after pause", ref_req, 1);

    for (int n = 0; n < NINIT; n++) begin
      chk(init_done == 0, "R2 init_done low before last start-up refresh", init_done, 0);
      do_ref();
    end
    chk(init_done == 1, "R2 init_done after eighth refresh", init_done, 1);
    chk(ref_req == 0, "R7 nothing owed at init", ref_req, 0);

    ok = 1;
    ref_gnt = 1;  // R6: grant ignored while nothing owed
    for (int k = 1; k <= IVL; k++) begin
      if (k == IVL - 1) ref_gnt = 0;
      @(negedge clk);
      if (k < IVL && (ref_req || ref_active || !ras_n || !cas_n)) ok = 0;
    end
    chk(ok, "R6 R7 idle until interval expires", ok, 1);
    chk(ref_req == 1, "R7 request at interval", ref_req, 1);

    ok = 1;
    repeat (2 * IVL) begin
      @(negedge clk);
      if (!ref_req || ref_active) ok = 0;
    end
    chk(ok, "R8 request held while owed", ok, 1);
    do_ref();
    chk(ref_req == 1, "R8 backlog after first", ref_req, 1);
    do_ref();
    chk(ref_req == 1, "R8 backlog after second", ref_req, 1);
    do_ref();
    chk(ref_req == 0, "R8 backlog cleared after third", ref_req, 0);

    repeat (170) @(negedge clk);
    served = 0;
    while (ref_req && served < 8) begin
      do_ref();
      served++;
    end
    chk(served == 3, "R9 owed count saturates", served, 3);
    chk(init_done == 1, "R2 init_done stays high", init_done, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule